// File: doc/BRIEF.md
# Stochastic Sweep-and-Count Integrator

This block drives the evaluation points of a stochastic numerical integration over the unit interval and gathers the answer. A sweep visits the point index k = 0, 1, …, M−1 in ascending order, with M = 2^M_BITS. It stays on each index for L = 2^L_BITS clocks. In every one of those clocks it compares k with DEG uniform random words supplied from outside. Each comparison gives one probe bit, and that bit is a one with probability k/M. An external function evaluator turns the probe bits into one stochastic output bit, and the block counts the ones it receives.

After the sweep has issued L·M points, the count y is the integral estimate. It is read as the fraction y / 2^(L_BITS+M_BITS), so no divider is needed. The counter has one bit more than the fraction width, which lets a full score of L·M (the value 1.0) be shown exactly. The evaluator may return its bit EVAL_LAT clocks after it sees the probe bits. The internal bookkeeping is delayed to match, so exactly the L·M returned bits are counted.

A one-clock pulse on `start` clears everything and begins a sweep, and it also restarts a sweep already in progress. A one-clock `done` pulse marks the point where `result` is final. The result then stays unchanged until the next start.

Top module: `sweep_integrator`

## Requirements
- R1: After reset, `result` is 0, `done` is 0 and every probe bit is 0.
- R2: In the clock after `start` is sampled, `result` is 0 and `done` is 0. A start during a sweep abandons it, and the new sweep runs its full length from that start.
- R3: Probe bit i is 1 exactly when random word i (bits [i*M_BITS +: M_BITS] of `rnd_words`) is less than the current index k. The bit is registered, so it appears one clock after the sweep state that produced it. In the n-th clock after start (n = 1 … L·M), k = (n−1) >> L_BITS, so each index is held for L clocks and the indices rise from 0 to M−1.
- R4: Each sweep issues exactly L·M points. With an evaluator that returns the probe bit of a word held at constant c, the final count is L·(M−1−c). With a constant-0 return bit the count is 0.
- R5: `result` is L_BITS+M_BITS+1 bits wide. When every returned bit is 1, the final value is exactly 2^(L_BITS+M_BITS), with only the top bit set, and it never goes above that value.
- R6: `done` is a single-clock pulse. It is high in the clock after edge number L·M+1+EVAL_LAT, counting the start-sampling edge as edge 0. `result` is final in that clock.
- R7: When the random words are uniform and the evaluator returns probe bit 0 (so f(x)=x), the result is close to L·M·(M−1)/(2M).
- R8: The returned bit has no effect outside a sweep. After `done`, `result` stays unchanged and `done` stays low, whatever `eval_bit` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the counters and begins a sweep |
| rnd_words | input | DEG*M_BITS | DEG uniform random words, word i at [i*M_BITS +: M_BITS] |
| eval_bit | input | 1 | Stochastic output bit returned by the evaluator |
| probe | output | DEG | Random bits, each one with probability k/M |
| done | output | 1 | One-clock pulse when the result is final |
| result | output | L_BITS+M_BITS+1 | Ones count, a fraction scaled by 2^(L_BITS+M_BITS) |

## Verification
A probe bit is due one clock after the sweep state that made it. The bench therefore samples the probe in the n-th clock after start and compares it with the index (n−1)>>L_BITS and the words it is holding. The returned bit is counted one edge after the probe appears, plus EVAL_LAT. The bench counts edges from the start edge and requires `done` after exactly L·M+1+EVAL_LAT edges, then reads the final `result` in that same clock. The bench drives all inputs and samples all outputs on the falling edge, so every expected value is tied to a known edge count.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_SWEEP = 1'b1
  } sweep_phase_e;

  // Width of the ones counter: fraction bits plus one so that 1.0 fits.
  function automatic int tally_width(input int l_bits, input int m_bits);
    return l_bits + m_bits + 1;
  endfunction

endpackage

// File: rtl/sweep_sequencer.sv
module sweep_sequencer
  import sweep_pkg::*;
#(
  parameter int M_BITS = 4,
  parameter int L_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              run,
  output logic              last,
  output logic [M_BITS-1:0] point
);

  localparam logic [M_BITS-1:0] POINT_MAX = {M_BITS{1'b1}};

  sweep_phase_e phase_q;
  logic [M_BITS-1:0] point_q;
  logic hold_end;

  // Hold counter: only present when each point is held for more than one clock.
  generate
    if (L_BITS == 0) begin : g_no_hold
      assign hold_end = 1'b1;
    end else begin : g_hold
      logic [L_BITS-1:0] hold_q;
      always_ff @(posedge clk) begin
        if (rst || start) begin
          hold_q <= '0;
        end else if (phase_q == PH_SWEEP) begin
          hold_q <= hold_q + 1'b1;
        end
      end
      assign hold_end = (hold_q == {L_BITS{1'b1}});
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      point_q <= '0;
    end else if (start) begin
      phase_q <= PH_SWEEP;
      point_q <= '0;
    end else if (phase_q == PH_SWEEP && hold_end) begin
      point_q <= point_q + 1'b1;
      if (point_q == POINT_MAX) begin
        phase_q <= PH_IDLE;
      end
    end
  end

  assign run   = (phase_q == PH_SWEEP);
  assign last  = run && hold_end && (point_q == POINT_MAX);
  assign point = point_q;

endmodule

// File: rtl/sweep_probe.sv
module sweep_probe #(
  parameter int DEG    = 3,
  parameter int M_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  run,
  input  logic                  last_in,
  input  logic [M_BITS-1:0]     point,
  input  logic [DEG*M_BITS-1:0] words,
  output logic [DEG-1:0]        probe,
  output logic                  tag_vld,
  output logic                  tag_last
);

  logic [DEG-1:0] cmp_bits;

  // One magnitude comparator per random word.
  generate
    for (genvar i = 0; i < DEG; i++) begin : g_cmp
      assign cmp_bits[i] = (words[i*M_BITS +: M_BITS] < point);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      probe    <= '0;
      tag_vld  <= 1'b0;
      tag_last <= 1'b0;
    end else begin
      probe    <= run ? cmp_bits : '0;
      tag_vld  <= run;
      tag_last <= last_in;
    end
  end

endmodule

// File: rtl/return_align.sv
module return_align #(
  parameter int LAT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic vld_in,
  input  logic last_in,
  output logic vld_out,
  output logic last_out
);

  generate
    if (LAT == 0) begin : g_pass
      assign vld_out  = vld_in;
      assign last_out = last_in;
    end else begin : g_delay
      logic [LAT-1:0] vld_sr;
      logic [LAT-1:0] last_sr;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          vld_sr  <= '0;
          last_sr <= '0;
        end else begin
          vld_sr[0]  <= vld_in;
          last_sr[0] <= last_in;
          for (int s = 1; s < LAT; s++) begin
            vld_sr[s]  <= vld_sr[s-1];
            last_sr[s] <= last_sr[s-1];
          end
        end
      end
      assign vld_out  = vld_sr[LAT-1];
      assign last_out = last_sr[LAT-1];
    end
  endgenerate

endmodule

// File: rtl/ones_tally.sv
module ones_tally #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          vld,
  input  logic          last,
  input  logic          bit_in,
  output logic [CW-1:0] count,
  output logic          done
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
      done  <= 1'b0;
    end else begin
      if (vld && bit_in) begin
        count <= count + 1'b1;
      end
      done <= vld && last;
    end
  end

endmodule

// File: rtl/sweep_integrator.sv
module sweep_integrator
  import sweep_pkg::*;
#(
  parameter int M_BITS   = 4,
  parameter int L_BITS   = 2,
  parameter int DEG      = 3,
  parameter int EVAL_LAT = 0,
  localparam int RES_W   = tally_width(L_BITS, M_BITS),
  localparam int WORDS_W = DEG * M_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WORDS_W-1:0] rnd_words,
  input  logic               eval_bit,
  output logic [DEG-1:0]     probe,
  output logic               done,
  output logic [RES_W-1:0]   result
);

  logic              seq_run;
  logic              seq_last;
  logic [M_BITS-1:0] seq_point;
  logic              tag_vld;
  logic              tag_last;
  logic              ret_vld;
  logic              ret_last;

  sweep_sequencer #(
    .M_BITS(M_BITS),
    .L_BITS(L_BITS)
  ) i_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .run  (seq_run),
    .last (seq_last),
    .point(seq_point)
  );

  sweep_probe #(
    .DEG   (DEG),
    .M_BITS(M_BITS)
  ) i_probe (
    .clk     (clk),
    .rst     (rst),
    .clr     (start),
    .run     (seq_run),
    .last_in (seq_last),
    .point   (seq_point),
    .words   (rnd_words),
    .probe   (probe),
    .tag_vld (tag_vld),
    .tag_last(tag_last)
  );

  return_align #(
    .LAT(EVAL_LAT)
  ) i_align (
    .clk     (clk),
    .rst     (rst),
    .clr     (start),
    .vld_in  (tag_vld),
    .last_in (tag_last),
    .vld_out (ret_vld),
    .last_out(ret_last)
  );

  ones_tally #(
    .CW(RES_W)
  ) i_tally (
    .clk   (clk),
    .rst   (rst),
    .clr   (start),
    .vld   (ret_vld),
    .last  (ret_last),
    .bit_in(eval_bit),
    .count (result),
    .done  (done)
  );

endmodule

// File: rtl/sweep_integrator_chk.sv
module sweep_integrator_chk #(
  parameter int RES_W = 7,
  parameter int FRAC  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic [RES_W-1:0] result
);

  localparam logic [RES_W-1:0] FULL = RES_W'(1) << FRAC;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (result == '0 && !done));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    result <= FULL);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (result == $past(result) || result == $past(result) + 1'b1));

  // R8
  hold_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (result == $past(result)));

endmodule

bind sweep_integrator sweep_integrator_chk #(
  .RES_W(RES_W),
  .FRAC (L_BITS + M_BITS)
) i_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .done  (done),
  .result(result)
);

// File: tb/test_sweep_integrator.sv
module test_sweep_integrator;

  localparam int M_BITS = 4;
  localparam int L_BITS = 2;
  localparam int DEG    = 3;
  localparam int M      = 1 << M_BITS;
  localparam int L      = 1 << L_BITS;
  localparam int LM     = L * M;
  localparam int RES_W  = L_BITS + M_BITS + 1;
  localparam int DONE_EDGES = LM + 1;

  // Vector: {mode[1:0], word[3:0], expected[6:0]}
  // mode 0: return probe[0]; 1: constant 1; 2: constant 0; 3: return probe[DEG-1]
  localparam int NVEC = 6;
  localparam logic [12:0] VECS [NVEC] = '{
    {2'd0, 4'd0,  7'd60},
    {2'd0, 4'd5,  7'd40},
    {2'd0, 4'd15, 7'd0},
    {2'd1, 4'd7,  7'd64},
    {2'd2, 4'd0,  7'd0},
    {2'd3, 4'd9,  7'd24}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [DEG*M_BITS-1:0] rnd_words = '0;
  logic eval_bit;
  logic [DEG-1:0] probe;
  logic done;
  logic [RES_W-1:0] result;
  logic [1:0] mode = 2'd2;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit chk_probe = 1'b0;
  bit rand_on = 1'b0;
  int probe_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  always_comb begin
    case (mode)
      2'd0: eval_bit = probe[0];
      2'd1: eval_bit = 1'b1;
      2'd2: eval_bit = 1'b0;
      default: eval_bit = probe[DEG-1];
    endcase
  end

  sweep_integrator #(
    .M_BITS(M_BITS),
    .L_BITS(L_BITS),
    .DEG(DEG),
    .EVAL_LAT(0)
  ) i_sweep_integrator (
    .clk(clk), .rst(rst), .start(start), .rnd_words(rnd_words),
    .eval_bit(eval_bit), .probe(probe), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_words(input logic [M_BITS-1:0] w);
    for (int i = 0; i < DEG; i++) rnd_words[i*M_BITS +: M_BITS] = w;
  endtask

  // Pulse start at a falling edge, then count edges until done is seen.
  task automatic sweep(output int edges);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (edges < 1000) begin
      @(negedge clk);
      edges++;
      if (chk_probe && edges <= LM) begin
        for (int i = 0; i < DEG; i++) begin
          if (probe[i] !== (rnd_words[i*M_BITS +: M_BITS] < ((edges - 1) >> L_BITS)))
            probe_bad++;
        end
      end
      if (rand_on) begin
        lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
        rnd_words = lfsr[DEG*M_BITS-1:0];
      end
      if (done) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int edges;
    logic [RES_W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(result == 0, "R1 result", int'(result), 0);
    check(done == 0, "R1 done", int'(done), 0);
    check(probe == 0, "R1 probe", int'(probe), 0);
    rst = 1'b0;
    @(negedge clk);

    // R4 R5 R6: vector table
    for (int v = 0; v < NVEC; v++) begin
      mode = VECS[v][12:11];
      fill_words(VECS[v][10:7]);
      sweep(edges);
      check(edges == DONE_EDGES, "R6 done timing", edges, DONE_EDGES);
      check(int'(result) == int'(VECS[v][6:0]), "R4 count", int'(result), int'(VECS[v][6:0]));
      if (mode == 2'd1)
        check(result == (1 << (L_BITS + M_BITS)), "R5 full scale", int'(result), 1 << (L_BITS + M_BITS));
    end

    // R3: probe bits per clock, distinct words
    mode = 2'd0;
    rnd_words = {4'd12, 4'd7, 4'd3};
    probe_bad = 0;
    chk_probe = 1'b1;
    sweep(edges);
    chk_probe = 1'b0;
    check(probe_bad == 0, "R3 probe mismatches", probe_bad, 0);
    check(result == L * (M - 1 - 3), "R3 count word0=3", int'(result), L * (M - 1 - 3));

    // R8: returned bit ignored after done
    held = result;
    mode = 2'd1;
    repeat (20) @(negedge clk);
    check(result == held, "R8 result held", int'(result), int'(held));
    check(done == 0, "R8 no done", int'(done), 0);

    // R2: restart in the middle of a sweep
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    check(result == 0, "R2 cleared by start", int'(result), 0);
    start = 1'b0;
    edges = 0;
    while (edges < 1000) begin
      @(negedge clk);
      edges++;
      if (done) break;
    end
    check(edges == DONE_EDGES, "R2 restart length", edges, DONE_EDGES);
    check(result == LM, "R2 restart count", int'(result), LM);

    // R7: identity evaluator with uniform random words
    mode = 2'd0;
    rand_on = 1'b1;
    sweep(edges);
    rand_on = 1'b0;
    check((int'(result) >= (L * (M - 1) / 2) - 14) && (int'(result) <= (L * (M - 1) / 2) + 14),
          "R7 estimate", int'(result), L * (M - 1) / 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule